// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This block takes an incoming frame as a byte stream and spreads it over a ring of 8-byte receive descriptors in system memory. Each descriptor holds one status/length word and one buffer-address word. The engine fetches a descriptor, stores bytes at the buffer address until the buffer limit is reached or the frame ends, then writes length and flags back and moves to the next slot. A slot can be the last in the ring, in which case the next pointer returns to the ring base. After each writeback, events mark a completed buffer or a completed frame.

Reception runs only while the engine's active flag is set. Software arms it with a start pulse. The engine sets the flag only if the slot at the pointer is free, and it drops the flag when the ring fills. A frame longer than the programmed frame limit is still stored, but its final descriptor is marked oversize. If the ring fills in the middle of a frame, the rest of that frame is thrown away.

Top module: `rx_desc_ring`

## Requirements
- R1: While `rx_active` is low, `in_ready` is high and incoming frames are consumed with no buffer write, no descriptor write and no event. Activation only takes effect at a frame boundary: the remaining bytes of a frame that was already under way are dropped.
- R2: A `rx_start` pulse while idle fetches the descriptor at the pointer, and `rx_active` rises only if that descriptor's free flag (word bit 31) is set. `base_load` while idle sets the pointer to `ring_base`.
- R3: Each descriptor receives min(bytes left in frame, `max_buf_len`) bytes. Byte k of a descriptor is written at (buffer address from the descriptor's second word) + k. The byte count goes into bits 15:0 of the descriptor's first word.
- R4: A writeback clears the free flag (bit 31) and keeps the wrap flag (bit 29). It sets the end flag (bit 27) only on a frame's final descriptor, together with a one-cycle `evt_frame`; every earlier descriptor instead gets the end flag cleared and `evt_buf`.
- R5: When a frame is longer than `max_frame_len` bytes, bit 21 of its final descriptor is set. It is clear on every other descriptor, and the frame is stored in full.
- R6: After a writeback, the next descriptor is at `ring_base` if the wrap flag was set, and otherwise at the old address + 8.
- R7: After a frame, the engine fetches the next descriptor. `rx_active` stays high if that descriptor is free and falls to 0 if it is not.
- R8: If the next descriptor is not free in the middle of a frame, `rx_active` falls and the rest of the frame is consumed with no further writes or events.
- R9: `in_ready` is low while a descriptor is being read or written back.
- R10: After reset, `rx_active` is low, `in_ready` is high, no memory request is made and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | AW | Byte address of the first descriptor |
| base_load | input | 1 | Load pointer from ring_base (idle only) |
| rx_start | input | 1 | Arm reception (idle only) |
| max_buf_len | input | 16 | Bytes per descriptor buffer |
| max_frame_len | input | 16 | Frame length above which the oversize flag is set |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of frame |
| in_ready | output | 1 | Byte accepted on this edge when high with in_valid |
| mem_rd_req | output | 1 | Descriptor word read; data returns next cycle |
| mem_wr_req | output | 1 | Descriptor first-word write |
| mem_addr | output | AW | Descriptor word address |
| mem_wr_data | output | 32 | Descriptor word written back |
| mem_rd_data | input | 32 | Read data, one cycle after mem_rd_req |
| buf_wr_en | output | 1 | Buffer byte write |
| buf_wr_addr | output | AW | Buffer byte address |
| buf_wr_byte | output | 8 | Buffer byte |
| rx_active | output | 1 | Reception armed |
| evt_buf | output | 1 | Non-final buffer closed |
| evt_frame | output | 1 | Final buffer of a frame closed |

## Verification
A wrong pointer or offset shows up at once as a bad address on the next byte write or descriptor writeback. A wrong split count shows up as a bad length field within the same descriptor, at most max_buf_len bytes later. A stale free or wrap flag shows up in `rx_active` a few cycles after the frame ends, or as a writeback that arrives when none was expected. The bench therefore compares every byte write and every descriptor write, in order, against a behavioural ring model on each clock. It also compares `rx_active` after every frame.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int LEN_W       = 16;
  localparam int DESC_STRIDE = 8;
  localparam int FB_EMPTY    = 15;
  localparam int FB_WRAP     = 13;
  localparam int FB_LAST     = 11;
  localparam int FB_LONG     = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_ACC, S_WB, S_DROP
  } rxd_state_e;

  // buffer reached its programmed capacity after `filled` bytes
  function automatic logic buf_full(input logic [LEN_W-1:0] filled,
                                    input logic [LEN_W-1:0] limit);
    return filled >= limit;
  endfunction

  // frame count (one bit wider, saturating) exceeds the frame limit
  function automatic logic over_limit(input logic [LEN_W:0] seen,
                                      input logic [LEN_W-1:0] limit);
    return seen > {1'b0, limit};
  endfunction

  // flags half-word written back into a filled descriptor
  function automatic logic [LEN_W-1:0] wb_flags(input logic [LEN_W-1:0] fetched,
                                                input logic last,
                                                input logic long_f);
    logic [LEN_W-1:0] f;
    f = fetched;
    f[FB_EMPTY] = 1'b0;
    f[FB_LAST]  = last;
    f[FB_LONG]  = last & long_f;
    return f;
  endfunction
endpackage

// File: rtl/rxd_count.sv
module rxd_count
  import rxd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_buf,
  input  logic             clr_frame,
  input  logic             beat,
  input  logic [LEN_W-1:0] max_buf,
  input  logic [LEN_W-1:0] max_frame,
  output logic [LEN_W-1:0] buf_cnt,
  output logic [LEN_W-1:0] len_now,
  output logic             full_now,
  output logic             long_now
);
  logic [LEN_W:0] frame_cnt;
  logic [LEN_W:0] frame_next;

  assign len_now    = buf_cnt + 1'b1;
  assign frame_next = (&frame_cnt) ? frame_cnt : frame_cnt + 1'b1;
  assign full_now   = buf_full(len_now, max_buf);
  assign long_now   = over_limit(frame_next, max_frame);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_cnt <= '0;
    end else if (clr_buf) begin
      buf_cnt <= '0;
    end else if (beat) begin
      buf_cnt <= len_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
    end else if (clr_frame) begin
      frame_cnt <= '0;
    end else if (beat) begin
      frame_cnt <= frame_next;
    end
  end
endmodule

// File: rtl/rxd_ptr.sv
module rxd_ptr
  import rxd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] ring_base,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP = AW'(DESC_STRIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= ring_base;
    end else if (advance) begin
      ptr <= wrap ? ring_base : ptr + STEP;
    end
  end
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [31:0]      mem_rd_data,
  input  logic [LEN_W-1:0] len_now,
  input  logic             full_now,
  input  logic             long_now,
  output logic             idle,
  output logic             in_ready,
  output logic             rd_req,
  output logic             addr_hi,
  output logic             wr_req,
  output logic [31:0]      wb_word,
  output logic             byte_we,
  output logic             clr_buf,
  output logic             clr_frame,
  output logic             ptr_adv,
  output logic             wrap,
  output logic [AW-1:0]    buf_base,
  output logic             rx_active,
  output logic             evt_frame,
  output logic             evt_buf,
  output logic             busy,
  output logic             decide
);
  rxd_state_e       state;
  logic             mid;
  logic             skip;
  logic [LEN_W-1:0] desc_flags;
  logic [LEN_W-1:0] wb_len;
  logic             wb_last;
  logic             wb_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rx_active  <= 1'b0;
      mid        <= 1'b0;
      skip       <= 1'b0;
      desc_flags <= '0;
      buf_base   <= '0;
      wb_len     <= '0;
      wb_last    <= 1'b0;
      wb_long    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (in_valid) skip <= !in_last;
          if (rx_start) begin
            mid   <= 1'b0;
            state <= S_F0;
          end
        end
        S_F0: state <= S_F1;
        S_F1: begin
          desc_flags <= mem_rd_data[31:16];
          state      <= S_F2;
        end
        S_F2: begin
          buf_base <= mem_rd_data[AW-1:0];
          if (desc_flags[FB_EMPTY]) begin
            rx_active <= 1'b1;
            state     <= S_ACC;
          end else begin
            rx_active <= 1'b0;
            state     <= mid ? S_DROP : S_IDLE;
          end
        end
        S_ACC: begin
          if (in_valid) begin
            if (skip) begin
              skip <= !in_last;
            end else if (in_last || full_now) begin
              wb_len  <= len_now;
              wb_last <= in_last;
              wb_long <= in_last & long_now;
              state   <= S_WB;
            end
          end
        end
        S_WB: begin
          mid   <= !wb_last;
          state <= S_F0;
        end
        S_DROP: begin
          if (in_valid && in_last) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign idle      = (state == S_IDLE);
  assign in_ready  = (state == S_IDLE) || (state == S_ACC) || (state == S_DROP);
  assign rd_req    = (state == S_F0) || (state == S_F1);
  assign addr_hi   = (state == S_F1);
  assign wr_req    = (state == S_WB);
  assign decide    = (state == S_F2);
  assign busy      = rd_req || decide || wr_req;
  assign byte_we   = (state == S_ACC) && in_valid && !skip;
  assign clr_buf   = wr_req || (idle && rx_start);
  assign clr_frame = (wr_req && wb_last) || (idle && rx_start);
  assign ptr_adv   = wr_req;
  assign wrap      = desc_flags[FB_WRAP];
  assign evt_frame = wr_req && wb_last;
  assign evt_buf   = wr_req && !wb_last;
  assign wb_word   = {wb_flags(desc_flags, wb_last, wb_long), wb_len};
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ring_base,
  input  logic             base_load,
  input  logic             rx_start,
  input  logic [LEN_W-1:0] max_buf_len,
  input  logic [LEN_W-1:0] max_frame_len,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             mem_rd_req,
  output logic             mem_wr_req,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wr_data,
  input  logic [31:0]      mem_rd_data,
  output logic             buf_wr_en,
  output logic [AW-1:0]    buf_wr_addr,
  output logic [7:0]       buf_wr_byte,
  output logic             rx_active,
  output logic             evt_buf,
  output logic             evt_frame
);
  localparam logic [AW-1:0] HI_WORD = AW'(4);

  logic             idle, addr_hi, byte_we, clr_buf, clr_frame, ptr_adv, wrap;
  logic             busy_desc, fetch_decide, full_now, long_now;
  logic [LEN_W-1:0] buf_cnt, len_now;
  logic [AW-1:0]    ptr, buf_base;

  rxd_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start),
    .in_valid(in_valid), .in_last(in_last), .mem_rd_data(mem_rd_data),
    .len_now(len_now), .full_now(full_now), .long_now(long_now),
    .idle(idle), .in_ready(in_ready), .rd_req(mem_rd_req), .addr_hi(addr_hi),
    .wr_req(mem_wr_req), .wb_word(mem_wr_data), .byte_we(byte_we),
    .clr_buf(clr_buf), .clr_frame(clr_frame), .ptr_adv(ptr_adv), .wrap(wrap),
    .buf_base(buf_base), .rx_active(rx_active), .evt_frame(evt_frame),
    .evt_buf(evt_buf), .busy(busy_desc), .decide(fetch_decide)
  );

  rxd_count u_count (
    .clk(clk), .rst_n(rst_n), .clr_buf(clr_buf), .clr_frame(clr_frame),
    .beat(byte_we), .max_buf(max_buf_len), .max_frame(max_frame_len),
    .buf_cnt(buf_cnt), .len_now(len_now), .full_now(full_now),
    .long_now(long_now)
  );

  rxd_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(idle && base_load), .advance(ptr_adv),
    .wrap(wrap), .ring_base(ring_base), .ptr(ptr)
  );

  assign mem_addr    = addr_hi ? ptr + HI_WORD : ptr;
  assign buf_wr_en   = byte_we;
  assign buf_wr_addr = buf_base + AW'(buf_cnt);
  assign buf_wr_byte = in_data;
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        busy_desc,
  input logic        fetch_decide,
  input logic        rx_active,
  input logic        mem_wr_req,
  input logic [31:0] mem_wr_data,
  input logic        evt_frame,
  input logic        evt_buf,
  input logic        buf_wr_en,
  input logic [15:0] max_buf_len
);
  // R9: no byte taken while a descriptor is in flight
  a_r9_stall_on_desc: assert property (@(posedge clk) disable iff (!rst_n)
    busy_desc |-> !in_ready);
  // R3: length field never above buffer capacity
  a_r3_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && max_buf_len != 16'd0) |-> (mem_wr_data[15:0] <= max_buf_len));
  // R4: filled descriptor is no longer free
  a_r4_free_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !mem_wr_data[31]);
  // R4: events are exclusive and tied to a writeback
  a_r4_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_frame, evt_buf}) && ((evt_frame || evt_buf) == mem_wr_req));
  // R4: frame event carries the end flag, buffer event does not
  a_r4_evt_matches_end: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> (mem_wr_data[27] == evt_frame));
  // R5: oversize flag only on a final descriptor
  a_r5_long_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_data[21]) |-> mem_wr_data[27]);
  // R1: buffer writes only while armed
  a_r1_write_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> rx_active);
  // R7: active flag only changes right after a descriptor decision
  a_r7_active_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active != $past(rx_active)) |-> $past(fetch_decide));
endmodule

bind rx_desc_ring rx_desc_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .busy_desc(busy_desc),
  .fetch_decide(fetch_decide), .rx_active(rx_active), .mem_wr_req(mem_wr_req),
  .mem_wr_data(mem_wr_data), .evt_frame(evt_frame), .evt_buf(evt_buf),
  .buf_wr_en(buf_wr_en), .max_buf_len(max_buf_len)
);

// File: tb/rx_desc_ring_test.sv
module rx_desc_ring_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic        base_load = 1'b0, rx_start = 1'b0;
  logic [15:0] max_buf_len = 16'd16, max_frame_len = 16'd40;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = 8'h0;
  logic        in_ready, mem_rd_req, mem_wr_req, buf_wr_en, rx_active, evt_buf, evt_frame;
  logic [31:0] mem_addr, mem_wr_data, buf_wr_addr;
  logic [31:0] mem_rd_data = 32'h0;
  logic [7:0]  buf_wr_byte;

  always #10 clk = ~clk;

  rx_desc_ring uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .base_load(base_load),
    .rx_start(rx_start), .max_buf_len(max_buf_len), .max_frame_len(max_frame_len),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data), .buf_wr_en(buf_wr_en),
    .buf_wr_addr(buf_wr_addr), .buf_wr_byte(buf_wr_byte), .rx_active(rx_active),
    .evt_buf(evt_buf), .evt_frame(evt_frame)
  );

  logic [31:0] dmem [0:255];
  logic [31:0] sh   [0:255];
  always @(posedge clk) begin
    if (mem_rd_req) mem_rd_data <= dmem[mem_addr[9:2]];
    if (mem_wr_req) dmem[mem_addr[9:2]] <= mem_wr_data;
  end

  int checks = 0, failures = 0, cyc = 0;
  logic [39:0] q_byte[$];
  logic [31:0] qd_addr[$], qd_data[$];
  bit          qd_last[$];
  logic [31:0] m_ptr = 32'h0;
  bit          m_active = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "R10", "watchdog expired", cyc, 0);
      finish_run();
    end
  end

  // per-clock comparison against the model's expected write streams
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_req || mem_wr_req)
        chk(!in_ready, "R9", "in_ready during descriptor access", in_ready, 0);
      if (buf_wr_en) begin
        if (q_byte.size() == 0) chk(1'b0, "R1", "unexpected byte write", buf_wr_addr, 0);
        else begin
          logic [39:0] e;
          e = q_byte.pop_front();
          chk({buf_wr_addr, buf_wr_byte} == e, "R3", "byte write addr/data",
              {buf_wr_addr, buf_wr_byte}, e);
        end
      end
      if (mem_wr_req) begin
        if (qd_addr.size() == 0) chk(1'b0, "R8", "unexpected descriptor write", mem_addr, 0);
        else begin
          logic [31:0] ea, ed;
          bit el;
          ea = qd_addr.pop_front(); ed = qd_data.pop_front(); el = qd_last.pop_front();
          chk(mem_addr == ea, "R6", "writeback address", mem_addr, ea);
          chk(mem_wr_data[15:0] == ed[15:0], "R3", "length field", mem_wr_data[15:0], ed[15:0]);
          chk(mem_wr_data[21] == ed[21], "R5", "oversize flag", mem_wr_data[21], ed[21]);
          chk(mem_wr_data[31:16] == ed[31:16], "R4", "flags", mem_wr_data[31:16], ed[31:16]);
          chk(evt_frame == el && evt_buf == !el, "R4", "event pulse",
              {evt_frame, evt_buf}, {el, !el});
        end
      end else begin
        chk(!evt_frame && !evt_buf, "R4", "event without writeback", {evt_frame, evt_buf}, 0);
      end
    end
  end

  function automatic logic [7:0] byte_of(input int fid, input int i);
    return 8'((fid * 7 + i) & 255);
  endfunction

  task automatic model_frame(input int n, input int fid);
    int rem, i, chunk;
    logic [31:0] d, bb;
    logic [15:0] fl;
    bit last, lng;
    if (!m_active) return;
    rem = n; i = 0;
    while (1) begin
      d = m_ptr; fl = sh[d[9:2]][31:16]; bb = sh[d[9:2] + 8'd1];
      chunk = (rem < int'(max_buf_len)) ? rem : int'(max_buf_len);
      for (int k = 0; k < chunk; k++) begin
        q_byte.push_back({bb + 32'(k), byte_of(fid, i)});
        i++;
      end
      rem -= chunk;
      last = (rem == 0);
      lng  = last && (n > int'(max_frame_len));
      fl[15] = 1'b0; fl[11] = last; fl[5] = lng;
      sh[d[9:2]] = {fl, 16'(chunk)};
      qd_addr.push_back(d); qd_data.push_back({fl, 16'(chunk)}); qd_last.push_back(last);
      m_ptr = fl[13] ? ring_base : d + 32'd8;
      if (!sh[m_ptr[9:2]][31]) begin m_active = 1'b0; break; end
      if (last) break;
    end
  endtask

  task automatic send_frame(input int n, input int fid);
    model_frame(n, fid);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = byte_of(fid, i); in_last = (i == n - 1);
      while (1) begin
        if (in_ready) begin @(posedge clk); #2; break; end
        @(posedge clk); #2;
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    repeat (8) @(posedge clk);
    #2;
  endtask

  task automatic start_rx(input bit load);
    base_load = load; rx_start = 1'b1;
    @(posedge clk); #2;
    base_load = 1'b0; rx_start = 1'b0;
    if (load) m_ptr = ring_base;
    if (!m_active) m_active = sh[m_ptr[9:2]][31];
    repeat (6) @(posedge clk);
    #2;
  endtask

  task automatic init_ring(input int nd, input int busy_slot);
    for (int k = 0; k < nd; k++) begin
      logic [31:0] w0;
      w0 = {1'b1, 1'b0, (k == nd - 1), 13'h0, 16'h0};
      if (k == busy_slot) w0[31] = 1'b0;
      dmem[8'h40 + 8'(2 * k)] = w0;       sh[8'h40 + 8'(2 * k)] = w0;
      dmem[8'h41 + 8'(2 * k)] = 32'h1000 + 32'(k * 256);
      sh[8'h41 + 8'(2 * k)]   = 32'h1000 + 32'(k * 256);
    end
  endtask

  task automatic check_active(input string tag);
    chk(rx_active == m_active, tag, "rx_active", rx_active, m_active);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) begin dmem[k] = 32'h0; sh[k] = 32'h0; end
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    chk(!rx_active && in_ready, "R10", "reset outputs", {rx_active, in_ready}, 2'b01);
    chk(!mem_rd_req && !mem_wr_req && !buf_wr_en && !evt_frame && !evt_buf, "R10",
        "no activity in reset", {mem_rd_req, mem_wr_req, buf_wr_en}, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    init_ring(4, -1);
    // R1: frame while disarmed is consumed silently
    send_frame(5, 1);
    check_active("R1");
    chk(in_ready, "R1", "ready while disarmed", in_ready, 1);
    // R2: arm with free slot
    start_rx(1'b1);
    check_active("R2");
    send_frame(10, 2);            // one descriptor, end flag
    check_active("R7");
    send_frame(20, 3);            // 16 + 4 across two descriptors
    check_active("R7");
    send_frame(30, 4);            // fills slot 3, wraps, slot 0 busy mid frame
    check_active("R8");
    send_frame(4, 5);             // R1: ring full, discarded
    check_active("R1");
    // second ring: oversize and exact-fit cases
    init_ring(4, -1);
    start_rx(1'b1);
    check_active("R2");
    send_frame(41, 6);            // 16,16,9 with oversize on final (R5)
    check_active("R7");
    send_frame(16, 7);            // exact fit in wrap slot, then ring full (R6, R7)
    check_active("R7");
    send_frame(3, 8);
    check_active("R1");
    // third ring: one-byte buffers, limit equality
    max_buf_len = 16'd1; max_frame_len = 16'd2;
    init_ring(4, -1);
    start_rx(1'b1);
    send_frame(2, 9);             // length equals limit: no oversize (R5)
    check_active("R7");
    send_frame(3, 10);            // mid-frame ring full, no oversize written (R8)
    check_active("R8");
    // R2: arming onto a busy slot leaves reception off
    max_buf_len = 16'd16; max_frame_len = 16'd40;
    init_ring(4, 0);
    start_rx(1'b1);
    check_active("R2");
    send_frame(6, 11);
    check_active("R1");
    chk(q_byte.size() == 0, "R3", "pending byte writes", q_byte.size(), 0);
    chk(qd_addr.size() == 0, "R4", "pending descriptor writes", qd_addr.size(), 0);
    finish_run();
  end
endmodule